// File: doc/BRIEF.md
# Circulating Token Ring Channel Arbiter

This block shares a set of channels among a ring of nodes. Each channel has exactly one token. While the channel is free, its token moves one node per clock around the ring. A node that wants a channel takes the token as it passes, which grants the node that channel alone. When the node has finished with the channel, it drops the grant and the token leaves the node towards its downstream neighbour. Nodes form a one-way ring in increasing node order and wrap from the last node to node 0. Grants therefore pass around the ring in round-robin order.

Every channel has a home node, which is its channel number modulo the node count. At reset, each token starts at its home node. On every lap, the home node takes in the passing token and sends it on again unchanged, even when nobody claims it. A token that a node has just released enters the ring after that node's capture point. The releasing node therefore cannot take the token back until the token has made a whole lap.

A node may hold several channels at once. A request for a channel whose token never arrives simply waits.

Top module: `tra_ring`

## Requirements
- R1: During reset and right after it, no grant is asserted, and the token of channel c sits at node (c mod NODES). A node requesting channel c is granted after ((n - home) mod NODES) + 1 clock edges, provided the channel is uncontested.
- R2: No channel is ever granted to more than one node at the same time.
- R3: A grant appears only on the edge after the token was at that node while the node requested that channel. A token that arrives at a node with no request moves to the next node on the next edge.
- R4: If a node asserts release for a channel it holds, the grant falls on the next edge, and on that same edge the token appears at node (n+1) mod NODES.
- R5: After a release, the releasing node's grant for that channel stays low for NODES edges. If the node still requests the channel and no other node does, the grant returns on the edge NODES+1 after the release.
- R6: When several nodes request a free channel, the first requester downstream of the token, in increasing node order with wrap-around, wins. The others win in turn as the token is released.
- R7: An uncontested request is granted within NODES edges.
- R8: A node can hold grants for several channels at once, and grants on different channels do not affect each other.
- R9: A request whose token is held elsewhere stays pending without limit. A free token that passes its home node unclaimed reaches the next node on the following edge.
- R10: A release for a channel that the node does not hold has no effect on any grant or token.
- R11: At every cycle, each channel has exactly one token, counted either on the ring or as a held grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NODES*CHANNELS | Request bits; bit n*CHANNELS+c is node n asking for channel c |
| rel_i | input | NODES*CHANNELS | Release bits, same indexing; honoured only while that grant is held |
| grant_o | output | NODES*CHANNELS | Grant bits, same indexing; at most one node per channel |

## Verification
The bench targets the following corner cases:
- Two nodes wait on one channel. A design that scanned in the wrong direction would grant the upstream node first.
- A node releases a channel and immediately wants it back. A design that re-inserted the token ahead of its own capture point would hand the grant straight back instead of after a full lap.
- A node releases a channel it does not hold. A design that did not gate this would create a second token, or drop the holder's grant.
- A channel is held indefinitely while another node waits. This exposes a design that times out, duplicates tokens or grants spuriously.
- A long random phase compares every grant bit each cycle against a bench model of token position and owner. That model catches any shift in timing.

// File: rtl/tra_pkg.sv
package tra_pkg;

  // Home node of a channel: where its token starts and gets regenerated.
  function automatic int home_of(input int chan, input int nodes);
    return chan % nodes;
  endfunction

  // Downstream neighbour on the one-way ring.
  function automatic int ring_next(input int node, input int nodes);
    return (node + 1) % nodes;
  endfunction

  // Upstream neighbour on the one-way ring.
  function automatic int ring_prev(input int node, input int nodes);
    return (node + nodes - 1) % nodes;
  endfunction

endpackage

// File: rtl/tra_slot.sv
// One channel inside one node: capture, hold, release and pass-through.
module tra_slot #(
  parameter bit IS_HOME = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_here,
  input  logic want,
  input  logic drop,
  output logic tok_out,
  output logic held,
  output logic regen
);

  logic held_q;
  logic take;
  logic give_back;

  // The token can only be present here while nobody holds it.
  assign take      = tok_here & want;
  assign give_back = held_q & drop;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= (held_q & ~drop) | take;
  end

  // A released token enters after this node's capture point, so it must
  // travel a full lap before this node can see it again.
  assign tok_out = (tok_here & ~want) | give_back;
  assign held    = held_q;
  assign regen   = IS_HOME & tok_here & ~want;

endmodule

// File: rtl/tra_node.sv
// One ring stage: a token register per channel plus its slots.
module tra_node #(
  parameter int NODES    = 8,
  parameter int CHANNELS = 4,
  parameter int NODE_ID  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] tok_arrive,
  input  logic [CHANNELS-1:0] want,
  input  logic [CHANNELS-1:0] drop,
  output logic [CHANNELS-1:0] tok_at,
  output logic [CHANNELS-1:0] tok_out,
  output logic [CHANNELS-1:0] held,
  output logic [CHANNELS-1:0] regen
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    localparam bit IS_HOME = (tra_pkg::home_of(c, NODES) == NODE_ID);
    logic tok_q;

    always_ff @(posedge clk) begin
      if (!rst_n) tok_q <= IS_HOME;
      else        tok_q <= tok_arrive[c];
    end

    assign tok_at[c] = tok_q;

    tra_slot #(.IS_HOME(IS_HOME)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tok_here(tok_q),
      .want    (want[c]),
      .drop    (drop[c]),
      .tok_out (tok_out[c]),
      .held    (held[c]),
      .regen   (regen[c])
    );
  end

endmodule

// File: rtl/tra_ring.sv
// Ring of nodes; tokens advance one node per clock.
module tra_ring #(
  parameter int NODES    = 8,
  parameter int CHANNELS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NODES*CHANNELS-1:0] req_i,
  input  logic [NODES*CHANNELS-1:0] rel_i,
  output logic [NODES*CHANNELS-1:0] grant_o
);

  localparam int W = NODES * CHANNELS;

  logic [W-1:0] tok_at;     // token present at each node's capture point
  logic [W-1:0] tok_fwd;    // token leaving each node this cycle
  logic [W-1:0] regen_evt;  // home node re-emitting an unclaimed token

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int PREV = tra_pkg::ring_prev(n, NODES);

    tra_node #(
      .NODES   (NODES),
      .CHANNELS(CHANNELS),
      .NODE_ID (n)
    ) u_node (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_arrive(tok_fwd[PREV*CHANNELS +: CHANNELS]),
      .want      (req_i[n*CHANNELS +: CHANNELS]),
      .drop      (rel_i[n*CHANNELS +: CHANNELS]),
      .tok_at    (tok_at[n*CHANNELS +: CHANNELS]),
      .tok_out   (tok_fwd[n*CHANNELS +: CHANNELS]),
      .held      (grant_o[n*CHANNELS +: CHANNELS]),
      .regen     (regen_evt[n*CHANNELS +: CHANNELS])
    );
  end

endmodule

// File: rtl/tra_ring_chk.sv
module tra_ring_chk #(
  parameter int NODES    = 8,
  parameter int CHANNELS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NODES*CHANNELS-1:0] req,
  input logic [NODES*CHANNELS-1:0] rel,
  input logic [NODES*CHANNELS-1:0] grant,
  input logic [NODES*CHANNELS-1:0] tok_at,
  input logic [NODES*CHANNELS-1:0] regen
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_c
    logic [NODES-1:0] gcol;
    logic [NODES-1:0] tcol;
    for (genvar n = 0; n < NODES; n++) begin : g_col
      assign gcol[n] = grant[n*CHANNELS+c];
      assign tcol[n] = tok_at[n*CHANNELS+c];
    end

    a_r2_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gcol));

    a_r11_one_token: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tcol) + $countones(gcol)) == 1);

    for (genvar n = 0; n < NODES; n++) begin : g_n
      localparam int I   = n*CHANNELS + c;
      localparam int NXT = tra_pkg::ring_next(n, NODES)*CHANNELS + c;

      a_r3_grant_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant[I]) |-> $past(tok_at[I] && req[I]));

      a_r4_release_hop: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[I] && rel[I]) |=> (!grant[I] && tok_at[NXT]));

      a_r9_regen_hop: assert property (@(posedge clk) disable iff (!rst_n)
        regen[I] |=> tok_at[NXT]);
    end
  end

endmodule

bind tra_ring tra_ring_chk #(.NODES(NODES), .CHANNELS(CHANNELS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req_i),
  .rel   (rel_i),
  .grant (grant_o),
  .tok_at(tok_at),
  .regen (regen_evt)
);

// File: tb/sim_tra_ring.sv
`timescale 1ns/1ps
module sim_tra_ring;
  localparam int N  = 8;
  localparam int CH = 4;
  localparam int W  = N * CH;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] req_r = '0;
  logic [W-1:0] rel_r = '0;
  logic [W-1:0] grant;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int pos [CH];  // ring node holding the free token, -1 if held
  int own [CH];  // holding node, -1 if free

  always #2.5 clk = ~clk;

  tra_ring #(.NODES(N), .CHANNELS(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_r), .rel_i(rel_r), .grant_o(grant)
  );

  function automatic int idx(input int n, input int c);
    return n*CH + c;
  endfunction

  function automatic void model_reset();
    for (int c = 0; c < CH; c++) begin
      pos[c] = c % N;
      own[c] = -1;
    end
  endfunction

  function automatic void model_step(input logic [W-1:0] rq, input logic [W-1:0] rl);
    for (int c = 0; c < CH; c++) begin
      if (own[c] >= 0) begin
        if (rl[idx(own[c], c)]) begin
          pos[c] = (own[c] + 1) % N;
          own[c] = -1;
        end
      end else if (rq[idx(pos[c], c)]) begin
        own[c] = pos[c];
        pos[c] = -1;
      end else begin
        pos[c] = (pos[c] + 1) % N;
      end
    end
  endfunction

  function automatic logic [W-1:0] model_grant();
    logic [W-1:0] g = '0;
    for (int c = 0; c < CH; c++)
      if (own[c] >= 0) g[idx(own[c], c)] = 1'b1;
    return g;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input int n, input int c, input logic exp, input string tag);
    chk(grant[idx(n, c)] === exp, tag, 64'(grant[idx(n, c)]), 64'(exp));
  endtask

  // One clock: inputs already driven, model follows the edge, compare after.
  task automatic tick();
    @(posedge clk);
    model_step(req_r, rel_r);
    @(negedge clk);
    chk(grant === model_grant(), "R2 grant vector vs model", 64'(grant), 64'(model_grant()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit r9_bad;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    chk(grant === '0, "R1 grant low in reset", 64'(grant), 64'd0);

    // Directed requests present from the first edge after reset.
    req_r[idx(5, 2)] = 1'b1;
    req_r[idx(3, 0)] = 1'b1;
    req_r[idx(6, 0)] = 1'b1;
    req_r[idx(1, 1)] = 1'b1;
    req_r[idx(1, 3)] = 1'b1;
    rst_n = 1'b1;
    chk(grant === '0, "R1 grant low after reset", 64'(grant), 64'd0);

    tick();                                   // edge 1
    chk_bit(1, 1, 1'b1, "R1 home token taken on first edge");
    tick(); tick();                           // edge 3
    chk_bit(5, 2, 1'b0, "R3 no early grant");
    tick();                                   // edge 4
    chk_bit(5, 2, 1'b1, "R1 grant after hop distance plus one");
    chk_bit(3, 0, 1'b1, "R6 first downstream requester wins");
    chk_bit(6, 0, 1'b0, "R6 later requester waits");
    tick(); tick(); tick();                   // edge 7
    chk_bit(1, 3, 1'b1, "R7 uncontested wait within one lap");
    chk_bit(1, 1, 1'b1, "R8 node holds two channels");

    rel_r[idx(3, 0)] = 1'b1;
    tick();                                   // edge 8
    rel_r[idx(3, 0)] = 1'b0;
    req_r[idx(3, 0)] = 1'b0;
    chk_bit(3, 0, 1'b0, "R4 grant drops after release");
    tick(); tick();                           // edge 10
    chk_bit(6, 0, 1'b0, "R6 token still in transit");
    tick();                                   // edge 11
    chk_bit(6, 0, 1'b1, "R6 next requester served");

    rel_r[idx(1, 1)] = 1'b1;
    tick();                                   // edge 12
    rel_r[idx(1, 1)] = 1'b0;
    chk_bit(1, 1, 1'b0, "R4 grant drops after release");
    repeat (7) tick();                        // edge 19
    chk_bit(1, 1, 1'b0, "R5 no reacquire before full lap");
    tick();                                   // edge 20
    chk_bit(1, 1, 1'b1, "R5 reacquire after full lap");

    rel_r[idx(4, 1)] = 1'b1;
    rel_r[idx(1, 2)] = 1'b1;
    tick();                                   // edge 21
    rel_r = '0;
    chk_bit(1, 1, 1'b1, "R10 foreign release ignored");
    chk_bit(5, 2, 1'b1, "R10 holder keeps grant");
    chk_bit(4, 1, 1'b0, "R10 no grant from stray release");

    req_r[idx(7, 1)] = 1'b1;
    r9_bad = 1'b0;
    repeat (40) begin
      tick();
      if (grant[idx(7, 1)] !== 1'b0) r9_bad = 1'b1;
    end
    chk(!r9_bad, "R9 request pends while channel held", 64'(r9_bad), 64'd0);

    rel_r[idx(1, 1)] = 1'b1;
    tick();
    rel_r = '0;
    repeat (5) tick();
    chk_bit(7, 1, 1'b0, "R6 token not yet at node 7");
    tick();
    chk_bit(7, 1, 1'b1, "R6 waiting node served before releaser");

    // Random phase checked against the model every cycle.
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < W; b++) begin
        req_r[b] = ($urandom_range(0, 3) == 0);
        rel_r[b] = ($urandom_range(0, 3) == 0);
      end
      tick();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule